// File: doc/BRIEF.md
# Serial Channel Command and Interrupt Controller

This block serves one channel of a serial controller. The CPU writes a byte to the channel's command register, and bits 5..3 of that byte pick an action. Most of these actions change the interrupt-pending bits and the status latches. The same block also holds the interrupt-enable register. The shift registers, the CRC engine and the receive FIFO are outside the block. They appear here only as single-cycle event inputs and as one "FIFO not empty" level.

The external-status snapshot freezes on the first change of a modem or break line. It stays frozen until the CPU re-arms it, so a short pulse stays visible. In first-character receive mode, a receive interrupt fires once per arming. After the CPU quiets the transmit interrupt, it stays quiet until the next load or the end of the CRC. When a clearing command and a new event land in the same cycle, the event always wins.

Top module: `sercmd_ctrl`

## Requirements
- R1: The command code is taken from `wr_data[5:3]` when `wr_en`=1 and `wr_sel`=0. Codes 0 and 7 change nothing except the loop flag. Any command write other than code 3 copies `wr_data[0]` into `loop_mode`. Bits 7:6 and 2:1 are ignored.
- R2: Code 1 pulses `abort_req` for exactly one cycle and sets `stat0[0]` (the end-of-message latch). A `tx_load` pulse clears that latch. If code 1 and `tx_load` arrive in the same cycle, code 1 wins.
- R3: `stat0[N:1]` mirrors `modem_lines` while the snapshot is open. The first difference captures the new line value, freezes the snapshot and sets the external pending source (`irq_src[0]`). While frozen, the snapshot holds that value even after the line returns.
- R4: Code 2 re-opens the snapshot. If the lines differ from the snapshot in that cycle, the new value is captured and the source stays pending. Otherwise the pending source clears.
- R5: Code 3 pulses `chan_rst` for one cycle. It clears the enable register, the loop flag, the snapshot, the end-of-message latch, all pending sources, `stat1` and `fifo_hold`.
- R6: The receive mode is set by enable bits 3:2 (0 off, 1 first-character, 2 or 3 every character). In mode 1, code 4 arms a one-shot. The next `rx_push` sets the receive source. If `rx_avail`=1 or `rx_push`=1 when code 4 is written, the source sets at once.
- R7: In modes 2 and 3, every `rx_push` sets the receive source. In every mode, `rx_pop` clears it unless an `rx_push` arrives in the same cycle.
- R8: `tx_empty` sets the transmit source unless it is blocked. Code 5 clears the source and sets the block. `tx_load` or `crc_done` releases the block. `tx_load` also clears the source.
- R9: `rx_special` ORs `rx_err` into `stat1` and sets the special source. In mode 1 it also sets `fifo_hold`. Code 6 clears `stat1`, the special source and `fifo_hold`.
- R10: `irq_src` is ordered [0] external, [1] receive, [2] transmit, [3] special. Each bit is pending AND enabled. The enables are bit 0 external, bit 1 transmit, receive mode nonzero, and bit 4 special, written by `wr_en`=1 with `wr_sel`=1. `irq` is the OR of `irq_src`.
- R11: If a clearing command (2, 5 or 6) and its source's event fall in the same cycle, the event's effect is what remains after that edge.
- R12: Synchronous `rst` clears every register, and every output reads 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = command register, 1 = interrupt-enable register |
| wr_data | input | 8 | Write data |
| modem_lines | input | N_MODEM | Live modem and break status lines |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | The CPU read a character |
| rx_avail | input | 1 | Receive FIFO not empty |
| rx_special | input | 1 | A special receive condition occurred |
| rx_err | input | N_ERR | Error flags that go with `rx_special` |
| tx_empty | input | 1 | The transmit buffer became empty |
| tx_load | input | 1 | The CPU loaded the transmit buffer |
| crc_done | input | 1 | CRC transmission finished |
| stat0 | output | N_MODEM+1 | Line snapshot in [N:1], end-of-message latch in [0] |
| stat1 | output | N_ERR | Latched receive error flags |
| irq_src | output | 4 | Enabled pending sources |
| irq | output | 1 | Interrupt request |
| chan_rst | output | 1 | One-cycle channel reset pulse |
| abort_req | output | 1 | One-cycle abort-send request |
| fifo_hold | output | 1 | Hold the special-condition character in the FIFO |
| loop_mode | output | 1 | Loop-back flag |

## Verification
Three clearing commands can collide with their own source's event in the same edge: error-clear with a special receive condition, transmit-quiet with a buffer-empty event, and re-arm with a line difference. The bench drives each command together with its event on the same clock. It then expects the error flags, the hold flag and the transmit source to be set again. For the re-arm, it expects a fresh capture rather than a release. A behavioural model is compared on every clock, so a collision resolved the wrong way shows up in the very next cycle.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int CMD_LSB = 3;
    localparam int CMD_W   = 3;
    localparam int N_SRC   = 4;
    localparam int SRC_EXT = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_TX  = 2;
    localparam int SRC_SP  = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP_LO    = 3'd0,
        CMD_ABORT     = 3'd1,
        CMD_EXT_REARM = 3'd2,
        CMD_CHAN_CLR  = 3'd3,
        CMD_RX_ARM    = 3'd4,
        CMD_TX_QUIET  = 3'd5,
        CMD_ERR_CLR   = 3'd6,
        CMD_NOP_HI    = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        RXI_OFF   = 2'd0,
        RXI_FIRST = 2'd1,
        RXI_ALL   = 2'd2,
        RXI_ALL_B = 2'd3
    } rxi_e;

    typedef struct packed {
        logic sp_en;
        rxi_e rx_mode;
        logic tx_en;
        logic ext_en;
    } ie_t;

    typedef struct packed {
        logic abort;
        logic rearm;
        logic chan_clr;
        logic rx_arm;
        logic tx_quiet;
        logic err_clr;
        logic loop_we;
        logic loop_val;
    } cmd_t;

    function automatic logic rx_on(input rxi_e m);
        return m != RXI_OFF;
    endfunction

    function automatic logic rx_every(input rxi_e m);
        return (m == RXI_ALL) || (m == RXI_ALL_B);
    endfunction

endpackage

// File: rtl/sercmd_decode.sv
module sercmd_decode
    import sercmd_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output cmd_t       cmd,
    output logic       ie_we
);
    cmd_e       code;
    logic       cmd_we;
    logic [3:0] unused_bits;

    assign unused_bits = {wr_data[7:6], wr_data[2:1]};
    assign cmd_we      = wr_en & ~wr_sel;
    assign ie_we       = wr_en & wr_sel;
    assign code        = cmd_e'(wr_data[CMD_LSB +: CMD_W]);

    always_comb begin
        cmd = '0;
        if (cmd_we) begin
            unique case (code)
                CMD_ABORT:     cmd.abort    = 1'b1;
                CMD_EXT_REARM: cmd.rearm    = 1'b1;
                CMD_CHAN_CLR:  cmd.chan_clr = 1'b1;
                CMD_RX_ARM:    cmd.rx_arm   = 1'b1;
                CMD_TX_QUIET:  cmd.tx_quiet = 1'b1;
                CMD_ERR_CLR:   cmd.err_clr  = 1'b1;
                default:       ;
            endcase
            cmd.loop_we  = (code != CMD_CHAN_CLR);
            cmd.loop_val = wr_data[0];
        end
    end
endmodule

// File: rtl/sercmd_extlatch.sv
module sercmd_extlatch #(
    parameter int N_MODEM = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               rearm,
    input  logic [N_MODEM-1:0] lines,
    output logic [N_MODEM-1:0] snap,
    output logic               held
);
    logic open_w;
    logic differs;

    assign open_w  = ~held | rearm;
    assign differs = (lines != snap);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            snap <= '0;
            held <= 1'b0;
        end else if (open_w && differs) begin
            snap <= lines;
            held <= 1'b1;
        end else if (rearm) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/sercmd_rxsrc.sv
module sercmd_rxsrc
    import sercmd_pkg::*;
#(
    parameter int N_ERR = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  rxi_e             mode,
    input  logic             arm_cmd,
    input  logic             err_clr,
    input  logic             push,
    input  logic             pop,
    input  logic             avail,
    input  logic             special,
    input  logic [N_ERR-1:0] err_in,
    output logic             rx_pend,
    output logic             sp_pend,
    output logic [N_ERR-1:0] err_q,
    output logic             hold
);
    logic armed;
    logic set_rx;
    logic arm_nx;
    logic first;

    assign first = (mode == RXI_FIRST);

    always_comb begin
        set_rx = rx_every(mode) & push;
        arm_nx = 1'b0;
        if (first) begin
            if (arm_cmd) begin
                set_rx = set_rx | avail | push;
                arm_nx = ~(avail | push);
            end else begin
                set_rx = set_rx | (armed & push);
                arm_nx = armed & ~push;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed   <= 1'b0;
            rx_pend <= 1'b0;
            sp_pend <= 1'b0;
            err_q   <= '0;
            hold    <= 1'b0;
        end else begin
            armed   <= arm_nx;
            rx_pend <= set_rx | (rx_pend & ~pop);
            sp_pend <= special | (sp_pend & ~err_clr);
            err_q   <= (err_clr ? '0 : err_q) | (special ? err_in : '0);
            hold    <= (special & first) | (hold & ~err_clr);
        end
    end
endmodule

// File: rtl/sercmd_txsrc.sv
module sercmd_txsrc (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic quiet,
    input  logic empty,
    input  logic load,
    input  logic crc_done,
    output logic tx_pend
);
    logic blocked;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            blocked <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            tx_pend <= (empty & ~blocked) | (tx_pend & ~quiet & ~load);
            blocked <= (quiet | blocked) & ~(load | crc_done);
        end
    end
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
    import sercmd_pkg::*;
#(
    parameter int N_MODEM = 4,
    parameter int N_ERR   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [7:0]         wr_data,
    input  logic [N_MODEM-1:0] modem_lines,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               rx_avail,
    input  logic               rx_special,
    input  logic [N_ERR-1:0]   rx_err,
    input  logic               tx_empty,
    input  logic               tx_load,
    input  logic               crc_done,
    output logic [N_MODEM:0]   stat0,
    output logic [N_ERR-1:0]   stat1,
    output logic [N_SRC-1:0]   irq_src,
    output logic               irq,
    output logic               chan_rst,
    output logic               abort_req,
    output logic               fifo_hold,
    output logic               loop_mode
);
    localparam int IE_W = $bits(ie_t);

    cmd_t               cmd;
    logic               ie_we;
    ie_t                ie_q;
    logic               eom_q;
    logic [N_MODEM-1:0] snap;
    logic               ext_held;
    logic               rx_pend;
    logic               sp_pend;
    logic               tx_pend;
    logic [N_SRC-1:0]   pend_v;
    logic [N_SRC-1:0]   en_v;

    sercmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmd     (cmd),
        .ie_we   (ie_we)
    );

    sercmd_extlatch #(.N_MODEM(N_MODEM)) u_ext (
        .clk   (clk),
        .rst   (rst),
        .clr   (cmd.chan_clr),
        .rearm (cmd.rearm),
        .lines (modem_lines),
        .snap  (snap),
        .held  (ext_held)
    );

    sercmd_rxsrc #(.N_ERR(N_ERR)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clr     (cmd.chan_clr),
        .mode    (ie_q.rx_mode),
        .arm_cmd (cmd.rx_arm),
        .err_clr (cmd.err_clr),
        .push    (rx_push),
        .pop     (rx_pop),
        .avail   (rx_avail),
        .special (rx_special),
        .err_in  (rx_err),
        .rx_pend (rx_pend),
        .sp_pend (sp_pend),
        .err_q   (stat1),
        .hold    (fifo_hold)
    );

    sercmd_txsrc u_tx (
        .clk      (clk),
        .rst      (rst),
        .clr      (cmd.chan_clr),
        .quiet    (cmd.tx_quiet),
        .empty    (tx_empty),
        .load     (tx_load),
        .crc_done (crc_done),
        .tx_pend  (tx_pend)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.chan_clr) begin
            ie_q      <= '0;
            loop_mode <= 1'b0;
            eom_q     <= 1'b0;
        end else begin
            if (ie_we)       ie_q      <= ie_t'(wr_data[IE_W-1:0]);
            if (cmd.loop_we) loop_mode <= cmd.loop_val;
            if (cmd.abort)   eom_q     <= 1'b1;
            else if (tx_load) eom_q    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_req <= 1'b0;
            chan_rst  <= 1'b0;
        end else begin
            abort_req <= cmd.abort;
            chan_rst  <= cmd.chan_clr;
        end
    end

    always_comb begin
        pend_v          = '0;
        en_v            = '0;
        pend_v[SRC_EXT] = ext_held;
        pend_v[SRC_RX]  = rx_pend;
        pend_v[SRC_TX]  = tx_pend;
        pend_v[SRC_SP]  = sp_pend;
        en_v[SRC_EXT]   = ie_q.ext_en;
        en_v[SRC_RX]    = rx_on(ie_q.rx_mode);
        en_v[SRC_TX]    = ie_q.tx_en;
        en_v[SRC_SP]    = ie_q.sp_en;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign irq_src[g] = pend_v[g] & en_v[g];
    end

    assign irq   = |irq_src;
    assign stat0 = {snap, eom_q};
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk #(
    parameter int N_MODEM = 4,
    parameter int N_ERR   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               wr_sel,
    input logic [7:0]         wr_data,
    input logic               rx_special,
    input logic [N_ERR-1:0]   rx_err,
    input logic               tx_empty,
    input logic               tx_load,
    input logic [N_MODEM:0]   stat0,
    input logic [N_ERR-1:0]   stat1,
    input logic [3:0]         irq_src,
    input logic               chan_rst,
    input logic               abort_req,
    input logic               fifo_hold,
    input logic               loop_mode
);
    logic       cw;
    logic [2:0] code;

    assign cw   = wr_en && !wr_sel;
    assign code = wr_data[5:3];

    p_null_loop_r1: assert property (@(posedge clk) disable iff (rst)
        cw && (code == 3'd0 || code == 3'd7) |=> loop_mode == $past(wr_data[0]));

    p_abort_r2: assert property (@(posedge clk) disable iff (rst)
        cw && code == 3'd1 |=> abort_req && stat0[0]);

    p_snap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        irq_src[0] && !(cw && (code == 3'd2 || code == 3'd3)) |=> $stable(stat0[N_MODEM:1]));

    p_chan_clr_r5: assert property (@(posedge clk) disable iff (rst)
        cw && code == 3'd3 |=> chan_rst && irq_src == '0 && stat1 == '0 && !fifo_hold && !loop_mode);

    p_tx_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cw && code == 3'd5 && !tx_empty && !tx_load |=> !irq_src[2]);

    p_err_clr_r9: assert property (@(posedge clk) disable iff (rst)
        cw && code == 3'd6 && !rx_special |=> stat1 == '0 && !fifo_hold);

    p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
        rx_special && rx_err != '0 && !(cw && code == 3'd3) |=> stat1 != '0);

    p_reset_r12: assert property (@(posedge clk)
        rst |=> irq_src == '0 && !abort_req && !chan_rst && stat1 == '0);
endmodule

bind sercmd_ctrl sercmd_chk #(.N_MODEM(N_MODEM), .N_ERR(N_ERR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rx_special (rx_special),
    .rx_err     (rx_err),
    .tx_empty   (tx_empty),
    .tx_load    (tx_load),
    .stat0      (stat0),
    .stat1      (stat1),
    .irq_src    (irq_src),
    .chan_rst   (chan_rst),
    .abort_req  (abort_req),
    .fifo_hold  (fifo_hold),
    .loop_mode  (loop_mode)
);

// File: tb/sim_sercmd_ctrl.sv
`timescale 1ns/1ps
module sim_sercmd_ctrl;
    localparam int NM = 4;
    localparam int NE = 3;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 0, wr_sel = 0;
    logic [7:0]    wr_data = '0;
    logic [NM-1:0] modem_lines = '0;
    logic          rx_push = 0, rx_pop = 0, rx_avail = 0, rx_special = 0;
    logic [NE-1:0] rx_err = '0;
    logic          tx_empty = 0, tx_load = 0, crc_done = 0;
    logic [NM:0]   stat0;
    logic [NE-1:0] stat1;
    logic [3:0]    irq_src;
    logic          irq, chan_rst, abort_req, fifo_hold, loop_mode;

    always #5 clk = ~clk;

    sercmd_ctrl #(.N_MODEM(NM), .N_ERR(NE)) u0 (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference state
    int m_ie, m_loop, m_snap, m_held, m_eom, m_abort, m_crst;
    int m_arm, m_rxp, m_err, m_spp, m_hold, m_txp, m_blk;
    int q_ops[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int code, mode;
        bit cw, c1, c2, c3, c4, c5, c6, st;
        cw   = wr_en && !wr_sel;
        code = int'(wr_data[5:3]);
        c1 = cw && code == 1; c2 = cw && code == 2; c3 = cw && code == 3;
        c4 = cw && code == 4; c5 = cw && code == 5; c6 = cw && code == 6;
        mode = (m_ie >> 2) & 3;
        if (cw) q_ops.push_back(code);
        if (rst) begin
            {m_ie, m_loop, m_snap, m_held, m_eom, m_abort, m_crst} = '0;
            {m_arm, m_rxp, m_err, m_spp, m_hold, m_txp, m_blk} = '0;
        end else if (c3) begin
            {m_ie, m_loop, m_snap, m_held, m_eom, m_abort} = '0;
            {m_arm, m_rxp, m_err, m_spp, m_hold, m_txp, m_blk} = '0;
            m_crst = 1;
        end else begin
            m_crst  = 0;
            m_abort = c1;
            if (wr_en && wr_sel) m_ie = int'(wr_data[4:0]);
            if (cw) m_loop = wr_data[0];
            if ((!m_held || c2) && int'(modem_lines) != m_snap) begin
                m_snap = int'(modem_lines); m_held = 1;
            end else if (c2) m_held = 0;
            if (c1) m_eom = 1; else if (tx_load) m_eom = 0;
            // receive
            st = (mode >= 2) && rx_push;
            if (mode == 1) begin
                if (c4) begin st = rx_avail || rx_push; m_arm = !(rx_avail || rx_push); end
                else begin st = m_arm && rx_push; if (rx_push) m_arm = 0; end
            end else m_arm = 0;
            if (st) m_rxp = 1; else if (rx_pop) m_rxp = 0;
            // special
            if (c6) begin m_err = 0; m_spp = 0; m_hold = 0; end
            if (rx_special) begin
                m_err = m_err | int'(rx_err); m_spp = 1;
                if (mode == 1) m_hold = 1;
            end
            // transmit
            if (tx_empty && !m_blk) m_txp = 1;
            else if (c5 || tx_load) m_txp = 0;
            if (tx_load || crc_done) m_blk = 0; else if (c5) m_blk = 1;
        end
    end

    function automatic int exp_src();
        int r;
        r = 0;
        if (m_held && (m_ie & 1)) r |= 1;
        if (m_rxp && ((m_ie >> 2) & 3) != 0) r |= 2;
        if (m_txp && (m_ie & 2)) r |= 4;
        if (m_spp && (m_ie & 16)) r |= 8;
        return r;
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(int'(irq_src) == exp_src(), "R10 irq_src model", irq_src, exp_src());
            chk(irq == (exp_src() != 0), "R10 irq model", irq, exp_src() != 0);
            chk(int'(stat0) == ((m_snap << 1) | m_eom), "R3 stat0 model", stat0, (m_snap << 1) | m_eom);
            chk(int'(stat1) == m_err, "R9 stat1 model", stat1, m_err);
            chk(fifo_hold == m_hold[0], "R9 hold model", fifo_hold, m_hold);
            chk(abort_req == m_abort[0], "R2 abort model", abort_req, m_abort);
            chk(chan_rst == m_crst[0], "R5 chan_rst model", chan_rst, m_crst);
            chk(loop_mode == m_loop[0], "R1 loop model", loop_mode, m_loop);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wcmd(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic wie(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = d;
        @(negedge clk); wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rx_push = 1; 1: rx_pop = 1; 2: tx_empty = 1;
            3: tx_load = 1; 4: crc_done = 1; default: rx_special = 1;
        endcase
        @(negedge clk);
        {rx_push, rx_pop, tx_empty, tx_load, crc_done, rx_special} = '0;
    endtask

    function automatic logic [7:0] cb(input int code, input bit b0);
        return {2'b00, 3'(code), 2'b00, b0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(irq_src == 0 && stat0 == 0 && stat1 == 0 && !irq, "R12 reset state", {stat0, irq_src}, 0);

        wie(8'h1B);
        wcmd(8'hC7);
        chk(loop_mode == 1 && irq_src == 0, "R1 code 0 keeps loop bit only", {loop_mode, irq_src}, 5'h10);
        wcmd(8'h3E);
        chk(loop_mode == 0 && irq_src == 0 && stat0 == 0, "R1 code 7 no effect", {loop_mode, irq_src}, 0);

        @(negedge clk); modem_lines = 4'b0010;
        @(negedge clk); modem_lines = 4'b0000;
        repeat (3) @(negedge clk);
        chk(stat0 == 5'b00100, "R3 short pulse held", stat0, 5'b00100);
        chk(irq_src == 4'b0001, "R3 external pending", irq_src, 1);

        wcmd(cb(2, 0));
        chk(stat0 == 0 && irq_src == 4'b0001, "R4 re-arm recaptures difference", {stat0, irq_src}, 1);
        wcmd(cb(2, 0));
        chk(irq_src == 0, "R4 re-arm releases", irq_src, 0);

        wcmd(cb(1, 0));
        chk(abort_req == 1 && stat0[0] == 1, "R2 abort pulse and eom", {abort_req, stat0[0]}, 3);
        @(negedge clk);
        chk(abort_req == 0 && stat0[0] == 1, "R2 abort one cycle", {abort_req, stat0[0]}, 1);
        pulse(3);
        chk(stat0[0] == 0, "R2 load clears eom", stat0[0], 0);

        pulse(2);
        chk(irq_src == 4'b0100, "R8 empty raises tx", irq_src, 4);
        wcmd(cb(5, 0));
        chk(irq_src == 0, "R8 quiet clears tx", irq_src, 0);
        pulse(2);
        chk(irq_src == 0, "R8 blocked empty ignored", irq_src, 0);
        pulse(4);
        pulse(2);
        chk(irq_src == 4'b0100, "R8 crc end releases block", irq_src, 4);
        pulse(3);
        chk(irq_src == 0, "R8 load clears tx", irq_src, 0);

        pulse(0);
        chk(irq_src == 4'b0010, "R7 every-char push", irq_src, 2);
        pulse(1);
        chk(irq_src == 0, "R7 pop clears", irq_src, 0);

        wie(8'h17);
        pulse(0);
        chk(irq_src == 0, "R6 unarmed push ignored", irq_src, 0);
        wcmd(cb(4, 0));
        chk(irq_src == 0, "R6 arm with empty fifo", irq_src, 0);
        pulse(0);
        chk(irq_src == 4'b0010, "R6 first char raises", irq_src, 2);
        pulse(1);
        pulse(0);
        chk(irq_src == 0, "R6 one-shot consumed", irq_src, 0);
        rx_avail = 1;
        wcmd(cb(4, 0));
        chk(irq_src == 4'b0010, "R6 stored char raises at once", irq_src, 2);
        rx_avail = 0;
        pulse(1);

        @(negedge clk); rx_special = 1; rx_err = 3'b101;
        @(negedge clk); rx_special = 0; rx_err = 0;
        chk(stat1 == 3'b101 && fifo_hold && irq_src == 4'b1000, "R9 special latches", {stat1, fifo_hold, irq_src}, {3'b101, 1'b1, 4'b1000});
        wcmd(cb(6, 0));
        chk(stat1 == 0 && !fifo_hold && irq_src == 0, "R9 error clear", {stat1, fifo_hold, irq_src}, 0);

        @(negedge clk); wr_en = 1; wr_data = cb(6, 0); rx_special = 1; rx_err = 3'b010;
        @(negedge clk); wr_en = 0; wr_data = 0; rx_special = 0; rx_err = 0;
        chk(stat1 == 3'b010 && fifo_hold && irq_src == 4'b1000, "R11 special beats error clear", {stat1, fifo_hold, irq_src}, {3'b010, 1'b1, 4'b1000});
        @(negedge clk); wr_en = 1; wr_data = cb(5, 0); tx_empty = 1;
        @(negedge clk); wr_en = 0; wr_data = 0; tx_empty = 0;
        chk(irq_src == 4'b1100, "R11 empty beats tx quiet", irq_src, 4'hC);

        wie(8'h01);
        chk(irq_src == 0 && !irq, "R10 masked sources", {irq, irq_src}, 0);
        wie(8'h12);
        chk(irq_src == 4'b1100 && irq, "R10 tx and special enabled", {irq, irq_src}, 5'h1C);

        wcmd(cb(3, 1));
        chk(chan_rst && irq_src == 0 && stat1 == 0 && !fifo_hold && !loop_mode, "R5 channel reset", {chan_rst, stat1, fifo_hold, loop_mode}, 6'h20);
        @(negedge clk);
        chk(!chan_rst, "R5 pulse one cycle", chan_rst, 0);
        wie(8'h1F);
        chk(irq_src == 0, "R5 pendings cleared", irq_src, 0);

        pulse(2);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(irq_src == 0 && stat0 == 0 && stat1 == 0 && !abort_req, "R12 mid-run reset", {stat0, irq_src}, 0);
        repeat (2) @(negedge clk);

        done = 1;
        if (q_ops.size() == 0) chk(0, "R1 no command seen", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule